// File: doc/BRIEF.md
# UART Transmit/Receive Byte Queue Pair with Level Triggers

This block sits between a register interface and a UART frame engine. It holds two independent byte queues, each 32 entries deep. The transmit queue takes bytes written by the host and hands them to the frame engine. The receive queue takes bytes from the frame engine and hands them to the host. Each queue has its own enable, its own synchronous flush, and a 2-bit level code. The level code decides when the queue raises its trigger flag. For transmit the flag means "room to refill". For receive it means "data waiting for service".

With its enable low, a queue shrinks to a single holding register. Its trigger then reports "holding register empty" for transmit, or "holding register full" for receive. A flush empties only the queue. The word the frame engine has already taken into its own shift stage is outside this block and is not affected. A byte that arrives at a full queue is dropped. The drop sets a sticky flag, and only a flush of that queue clears the flag.

Each queue is controlled by a three-state occupancy machine with the states Q_EMPTY, Q_PART and Q_FULL. From any state a flush goes to Q_EMPTY. From Q_EMPTY, an accepted push goes to Q_FULL when the capacity is one, and to Q_PART otherwise. From Q_PART, a push that reaches capacity goes to Q_FULL, and a pop that leaves the queue empty goes to Q_EMPTY. Any other mix of pushes and pops stays in Q_PART. From Q_FULL, a pop goes to Q_EMPTY when the capacity is one, and to Q_PART otherwise. A push in Q_FULL is refused. Reads are first-word-fall-through: the head byte is visible before the pop.

Top module: `uart_fifo_pair`

## Requirements
- R1: Each queue delivers bytes in the order written, with the head byte visible on its data output before the pop. Its count output gives the number of stored bytes, from 0 to 32.
- R2: With the transmit queue enabled, tx_trig is high in every cycle where the free space (32 minus tx_count) is at least the threshold for tx_lvl. The thresholds are 2'b00 = 30, 2'b01 = 24, 2'b10 = 16 and 2'b11 = 8. In all other cycles tx_trig is low.
- R3: With the receive queue enabled, rx_trig is high in every cycle where rx_count is at least the threshold for rx_lvl. The thresholds are 2'b00 = 1, 2'b01 = 8, 2'b10 = 18 and 2'b11 = 28. In all other cycles rx_trig is low.
- R4: With its enable low, a queue holds at most one byte. With the transmit enable low, tx_trig equals "tx_count is 0". With the receive enable low, rx_trig equals "rx_count is 1".
- R5: While a flush input is high, that queue's count reads 0 from the next cycle on, and pushes into that queue are ignored. A flush also clears that queue's sticky flag. The other queue is unaffected.
- R6: A tx_wr while tx_count is 32 is dropped and leaves the stored bytes and the count unchanged. From the next cycle, tx_overflow is high, and it stays high until tx_flush.
- R7: An rx_put while rx_count is 32 is dropped and leaves the stored bytes and the count unchanged. From the next cycle, rx_overrun is high, and it stays high until rx_flush.
- R8: A pop from an empty queue has no effect. A push and a pop in the same cycle on a partly filled queue leave the count unchanged.
- R9: After reset, both counts are 0, tx_avail, rx_avail, tx_overflow, rx_overrun and rx_trig are 0, and tx_trig is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_fifo_en | input | 1 | 1 = transmit queue of 32, 0 = single holding register |
| rx_fifo_en | input | 1 | 1 = receive queue of 32, 0 = single holding register |
| tx_flush | input | 1 | Holds the transmit queue empty while high |
| rx_flush | input | 1 | Holds the receive queue empty while high |
| tx_lvl | input | 2 | Transmit trigger level code |
| rx_lvl | input | 2 | Receive trigger level code |
| tx_wr | input | 1 | Host write strobe into the transmit queue |
| tx_wdata | input | 8 | Host write byte |
| tx_take | input | 1 | Frame engine takes the transmit head byte |
| tx_avail | output | 1 | Transmit queue holds at least one byte |
| tx_byte | output | 8 | Transmit head byte |
| tx_count | output | 6 | Transmit occupancy |
| tx_trig | output | 1 | Transmit refill trigger |
| tx_overflow | output | 1 | Sticky: a host write was dropped |
| rx_put | input | 1 | Frame engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_rd | input | 1 | Host read strobe, pops the receive head |
| rx_avail | output | 1 | Receive queue holds at least one byte |
| rx_rdata | output | 8 | Receive head byte |
| rx_count | output | 6 | Receive occupancy |
| rx_trig | output | 1 | Receive service trigger |
| rx_overrun | output | 1 | Sticky: a received byte was dropped |

## Verification
The bench fills each queue to one entry short of every level code's threshold, then adds one byte, so that an off-by-one comparison or a swapped code table shows up as a trigger on the wrong side of the boundary. It writes into a full queue and checks that the extra byte never reaches the output stream. A design that wraps its pointer would instead overwrite the oldest byte or let the count roll over. Flush is held high together with pushes, and the check confirms that the other queue keeps its contents. This catches a flush that is treated as a one-shot, or one that is wired to both queues. The single-register mode, pops from an empty queue, and a push and pop in the same cycle are checked as well, which exposes capacity, underflow and count-update mistakes.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } qstate_t;

    // Free-space threshold for the transmit trigger, scaled from depth.
    function automatic int tx_free_thr(input logic [1:0] code, input int depth);
        unique case (code)
            2'b00:   return depth - 2;
            2'b01:   return (depth * 3) / 4;
            2'b10:   return depth / 2;
            default: return depth / 4;
        endcase
    endfunction

    // Fill threshold for the receive trigger, scaled from depth.
    function automatic int rx_fill_thr(input logic [1:0] code, input int depth);
        unique case (code)
            2'b00:   return 1;
            2'b01:   return depth / 4;
            2'b10:   return (depth * 9) / 16;
            default: return (depth * 7) / 8;
        endcase
    endfunction

endpackage

// File: rtl/uart_fq_queue.sv
module uart_fq_queue
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          drop
);

    localparam logic [CW-1:0] CAP_Q = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_H = CW'(1);

    qstate_t        state, state_nxt;
    logic [W-1:0]   mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  count_nxt, cap;
    logic           do_push, do_pop;

    assign cap     = en ? CAP_Q : CAP_H;
    assign do_push = push && !flush && (state != Q_FULL);
    assign do_pop  = pop  && !flush && (state != Q_EMPTY);

    always_comb begin
        count_nxt = count;
        if (flush) begin
            count_nxt = '0;
        end else begin
            unique case ({do_push, do_pop})
                2'b10:   count_nxt = count + CW'(1);
                2'b01:   count_nxt = count - CW'(1);
                default: count_nxt = count;
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            Q_EMPTY: if (!flush && do_push)
                         state_nxt = (count_nxt >= cap) ? Q_FULL : Q_PART;
            Q_PART:  if (flush || count_nxt == '0) state_nxt = Q_EMPTY;
                     else if (count_nxt >= cap)    state_nxt = Q_FULL;
            Q_FULL:  if (flush || count_nxt == '0) state_nxt = Q_EMPTY;
                     else if (do_pop)              state_nxt = Q_PART;
            default: state_nxt = Q_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            count <= count_nxt;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (do_push) wr_ptr <= wr_ptr + AW'(1);
                if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Outputs
    always_comb begin
        head  = mem[rd_ptr];
        empty = (state == Q_EMPTY);
        full  = (state == Q_FULL);
        drop  = push && !flush && (state == Q_FULL);
    end

    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP_Q);
    a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0) && empty);
    a_r6_full_push_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (count == $past(count)));
    a_r8_empty_pop_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> (count == '0));
    a_r8_push_pop_balance: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !full && push && pop && !flush) |=> $stable(count));

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_fifo_en,
    input  logic          rx_fifo_en,
    input  logic          tx_flush,
    input  logic          rx_flush,
    input  logic [1:0]    tx_lvl,
    input  logic [1:0]    rx_lvl,
    input  logic          tx_wr,
    input  logic [W-1:0]  tx_wdata,
    input  logic          tx_take,
    output logic          tx_avail,
    output logic [W-1:0]  tx_byte,
    output logic [CW-1:0] tx_count,
    output logic          tx_trig,
    output logic          tx_overflow,
    input  logic          rx_put,
    input  logic [W-1:0]  rx_byte,
    input  logic          rx_rd,
    output logic          rx_avail,
    output logic [W-1:0]  rx_rdata,
    output logic [CW-1:0] rx_count,
    output logic          rx_trig,
    output logic          rx_overrun
);

    logic tx_empty, tx_full, tx_drop;
    logic rx_empty, rx_full, rx_drop;

    uart_fq_queue #(.DEPTH(DEPTH), .W(W)) u_txq (
        .clk(clk), .rst_n(rst_n), .en(tx_fifo_en), .flush(tx_flush),
        .push(tx_wr), .push_data(tx_wdata), .pop(tx_take),
        .head(tx_byte), .count(tx_count), .empty(tx_empty),
        .full(tx_full), .drop(tx_drop)
    );

    uart_fq_queue #(.DEPTH(DEPTH), .W(W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .en(rx_fifo_en), .flush(rx_flush),
        .push(rx_put), .push_data(rx_byte), .pop(rx_rd),
        .head(rx_rdata), .count(rx_count), .empty(rx_empty),
        .full(rx_full), .drop(rx_drop)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_overflow <= 1'b0;
            rx_overrun  <= 1'b0;
        end else begin
            if (tx_flush)     tx_overflow <= 1'b0;
            else if (tx_drop) tx_overflow <= 1'b1;
            if (rx_flush)     rx_overrun  <= 1'b0;
            else if (rx_drop) rx_overrun  <= 1'b1;
        end
    end

    int tx_free;
    always_comb begin
        tx_free  = DEPTH - int'(tx_count);
        tx_avail = !tx_empty;
        rx_avail = !rx_empty;
        tx_trig  = tx_fifo_en ? (tx_free >= tx_free_thr(tx_lvl, DEPTH)) : tx_empty;
        rx_trig  = rx_fifo_en ? (int'(rx_count) >= rx_fill_thr(rx_lvl, DEPTH)) : rx_full;
    end

    a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_overflow && !tx_flush) |=> tx_overflow);
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !rx_flush) |=> rx_overrun);
    a_r6_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_overflow) |-> $past(tx_wr && tx_full));
    a_r5_flush_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush && !rx_flush && !rx_put && !rx_rd) |=> $stable(rx_count));

endmodule

// File: tb/tb_uart_fifo_pair.sv
`timescale 1ns/1ps
module tb_uart_fifo_pair;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_fifo_en = 1'b1, rx_fifo_en = 1'b1;
    logic tx_flush = 1'b0, rx_flush = 1'b0;
    logic [1:0] tx_lvl = 2'b00, rx_lvl = 2'b00;
    logic tx_wr = 1'b0, tx_take = 1'b0, rx_put = 1'b0, rx_rd = 1'b0;
    logic [7:0] tx_wdata = '0, rx_byte = '0;
    logic tx_avail, tx_trig, tx_overflow, rx_avail, rx_trig, rx_overrun;
    logic [7:0] tx_byte, rx_rdata;
    logic [5:0] tx_count, rx_count;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam int TXT[4] = '{30, 24, 16, 8};
    localparam int RXT[4] = '{1, 8, 18, 28};

    always #2.5 clk = ~clk;

    uart_fifo_pair dut (
        .clk(clk), .rst_n(rst_n), .tx_fifo_en(tx_fifo_en), .rx_fifo_en(rx_fifo_en),
        .tx_flush(tx_flush), .rx_flush(rx_flush), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_take(tx_take), .tx_avail(tx_avail),
        .tx_byte(tx_byte), .tx_count(tx_count), .tx_trig(tx_trig),
        .tx_overflow(tx_overflow), .rx_put(rx_put), .rx_byte(rx_byte), .rx_rd(rx_rd),
        .rx_avail(rx_avail), .rx_rdata(rx_rdata), .rx_count(rx_count),
        .rx_trig(rx_trig), .rx_overrun(rx_overrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Each op: drive at a falling edge, release at the next; the result is
    // then settled at that second falling edge.
    task automatic wr_tx(input logic [7:0] b);
        @(negedge clk); tx_wdata = b; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
    endtask
    task automatic take_tx();
        @(negedge clk); tx_take = 1'b1;
        @(negedge clk); tx_take = 1'b0;
    endtask
    task automatic put_rx(input logic [7:0] b);
        @(negedge clk); rx_byte = b; rx_put = 1'b1;
        @(negedge clk); rx_put = 1'b0;
    endtask
    task automatic rd_rx();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask
    task automatic flush_tx();
        @(negedge clk); tx_flush = 1'b1;
        @(negedge clk); tx_flush = 1'b0;
    endtask
    task automatic flush_rx();
        @(negedge clk); rx_flush = 1'b1;
        @(negedge clk); rx_flush = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9 tx_count", tx_count, 0);
        chk("R9 rx_count", rx_count, 0);
        chk("R9 tx_avail", tx_avail, 0);
        chk("R9 rx_avail", rx_avail, 0);
        chk("R9 tx_trig", tx_trig, 1);
        chk("R9 rx_trig", rx_trig, 0);
        chk("R9 flags", {tx_overflow, rx_overrun}, 0);
    endtask

    task automatic t_order();
        wr_tx(8'hA1); wr_tx(8'hB2); wr_tx(8'hC3);
        chk("R1 tx_count", tx_count, 3);
        chk("R1 head first", tx_byte, 8'hA1);
        take_tx();
        chk("R1 head second", tx_byte, 8'hB2);
        take_tx();
        chk("R1 head third", tx_byte, 8'hC3);
        take_tx();
        chk("R1 empty after drain", tx_avail, 0);
    endtask

    task automatic t_tx_levels();
        for (int c = 0; c < 4; c++) begin
            tx_lvl = 2'(c);
            flush_tx();
            for (int i = 0; i < 32 - TXT[c]; i++) wr_tx(8'(i));
            chk($sformatf("R2 code%0d at threshold", c), tx_trig, 1);
            wr_tx(8'hFF);
            chk($sformatf("R2 code%0d past threshold", c), tx_trig, 0);
        end
    endtask

    task automatic t_tx_full();
        int bad = 0;
        flush_tx();
        for (int i = 0; i < 32; i++) wr_tx(8'(i + 16));
        chk("R6 full count", tx_count, 32);
        chk("R6 no overflow yet", tx_overflow, 0);
        wr_tx(8'hEE);
        chk("R6 count after drop", tx_count, 32);
        chk("R6 overflow set", tx_overflow, 1);
        for (int i = 0; i < 32; i++) begin
            if (tx_byte != 8'(i + 16)) bad++;
            take_tx();
        end
        chk("R6 stream intact", bad, 0);
        chk("R6 overflow sticky", tx_overflow, 1);
    endtask

    task automatic t_flush_iso();
        put_rx(8'h11); put_rx(8'h22); put_rx(8'h33);
        wr_tx(8'h01); wr_tx(8'h02);
        @(negedge clk); tx_flush = 1'b1; tx_wr = 1'b1; tx_wdata = 8'h55;
        @(negedge clk);
        @(negedge clk);
        chk("R5 held empty with writes", tx_count, 0);
        tx_flush = 1'b0; tx_wr = 1'b0;
        @(negedge clk);
        chk("R5 still empty after release", tx_count, 0);
        chk("R5 overflow cleared", tx_overflow, 0);
        chk("R5 rx untouched", rx_count, 3);
        chk("R5 rx head untouched", rx_rdata, 8'h11);
    endtask

    task automatic t_rx_levels();
        for (int c = 0; c < 4; c++) begin
            rx_lvl = 2'(c);
            flush_rx();
            for (int i = 0; i < RXT[c] - 1; i++) put_rx(8'(i));
            chk($sformatf("R3 code%0d below threshold", c), rx_trig, 0);
            put_rx(8'h77);
            chk($sformatf("R3 code%0d at threshold", c), rx_trig, 1);
        end
    endtask

    task automatic t_rx_full();
        int bad = 0;
        flush_rx();
        for (int i = 0; i < 32; i++) put_rx(8'(i * 3));
        put_rx(8'hEE);
        chk("R7 count after drop", rx_count, 32);
        chk("R7 overrun set", rx_overrun, 1);
        for (int i = 0; i < 32; i++) begin
            if (rx_rdata != 8'(i * 3)) bad++;
            rd_rx();
        end
        chk("R7 stream intact", bad, 0);
        chk("R7 overrun sticky", rx_overrun, 1);
        flush_rx();
        chk("R7 overrun cleared by flush", rx_overrun, 0);
    endtask

    task automatic t_holding();
        flush_tx();
        tx_fifo_en = 1'b0;
        @(negedge clk);
        chk("R4 tx empty trig", tx_trig, 1);
        wr_tx(8'h5A);
        chk("R4 tx one held", tx_count, 1);
        chk("R4 tx trig low", tx_trig, 0);
        wr_tx(8'h6B);
        chk("R4 tx second dropped", tx_count, 1);
        chk("R4 tx overflow", tx_overflow, 1);
        chk("R4 tx head kept", tx_byte, 8'h5A);
        take_tx();
        chk("R4 tx trig after take", tx_trig, 1);
        flush_rx();
        rx_fifo_en = 1'b0;
        @(negedge clk);
        chk("R4 rx trig empty", rx_trig, 0);
        put_rx(8'hC1);
        chk("R4 rx trig full", rx_trig, 1);
        put_rx(8'hC2);
        chk("R4 rx second dropped", rx_count, 1);
        chk("R4 rx overrun", rx_overrun, 1);
        chk("R4 rx head kept", rx_rdata, 8'hC1);
        tx_fifo_en = 1'b1; rx_fifo_en = 1'b1;
        flush_tx(); flush_rx();
    endtask

    task automatic t_edges();
        take_tx();
        chk("R8 pop empty count", tx_count, 0);
        chk("R8 pop empty avail", tx_avail, 0);
        wr_tx(8'h01); wr_tx(8'h02);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = 8'h03; tx_take = 1'b1;
        @(negedge clk); tx_wr = 1'b0; tx_take = 1'b0;
        chk("R8 push+pop count", tx_count, 2);
        chk("R8 push+pop head", tx_byte, 8'h02);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_tx_levels();
        t_tx_full();
        t_flush_iso();
        t_rx_levels();
        t_rx_full();
        t_holding();
        t_edges();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule